// File: doc/BRIEF.md
# Compare-Select Load Execution Unit

This unit is the execution slice of a single-cycle core that handles three compare-select operations next to the ordinary register-register path. It takes the two register operands of an instruction and an operation code. For the plain select it returns the larger operand. For the select-load it reads the data word whose address is the larger operand. For the select-load-select it reads that same word and returns whichever is larger, the word or the first operand. The result and a write enable go straight to the register file write port in the same cycle.

The compare is signed two's-complement. It is computed on a 33-bit difference, so wrap-around in the subtraction cannot flip the result. The second selection needs the loaded word, so it uses its own comparator rather than sharing the first one. A 16-word array with a clocked preload port stands in for data memory. It is read without a clock, which lets the whole compare, read and compare chain settle inside one cycle.

Top module: `csl_exec_unit`

## Requirements
- R1: With `op_i` = 2'b00 (idle), `wb_en_o` is 0 and `wb_data_o` is 0.
- R2: With `op_i` = 2'b01 (select), `wb_data_o` equals the signed maximum of `src_a_i` and `src_b_i`.
- R3: The signed compare gives the right answer at the extremes of the range, for example 32'h7FFFFFFF against 32'h80000000, where a 32-bit subtraction would overflow.
- R4: With `op_i` = 2'b10 (select-load), `wb_data_o` equals the array word indexed by bits [5:2] of the signed maximum of the two operands.
- R5: Address bits [1:0] and bits [31:6] of the selected address do not affect which word is read.
- R6: With `op_i` = 2'b11 (select-load-select), `wb_data_o` equals the signed maximum of `src_a_i` and the word read as in R4.
- R7: `wb_en_o` is 1 for `op_i` values 2'b01, 2'b10 and 2'b11.
- R8: For both load operations, `mem_addr_o` equals the signed maximum of the two operands. All results are combinational and are valid in the cycle the inputs are applied.
- R9: A preload write (`pre_we_i` = 1) stores `pre_data_i` into word `pre_idx_i` at the rising clock edge. While `rst_n` is low at a rising edge, every word is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the preload port and the array reset |
| rst_n | input | 1 | Synchronous active-low reset; clears the array |
| op_i | input | 2 | Operation: 00 idle, 01 select, 10 select-load, 11 select-load-select |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand |
| pre_we_i | input | 1 | Preload write enable |
| pre_idx_i | input | 4 | Preload word index |
| pre_data_i | input | 32 | Preload word value |
| wb_en_o | output | 1 | Register write-back enable |
| wb_data_o | output | 32 | Register write-back value |
| mem_addr_o | output | 32 | Byte address presented to the data array |

## Verification
Every operation result, and the write-back enable, is due in the same cycle as its inputs, with no register on the way. The bench therefore applies operands on a falling edge and samples two nanoseconds later, before the next rising edge. A preload takes effect at the first rising edge while its write enable is high, so loads that depend on it are checked only from the following falling edge. The same timing holds for the array clear after a reset.

// File: rtl/csl_pkg.sv
// Package: shared operation codes and widths for the compare-select unit.
// Assumes a 2-bit operation code supplied by an external decoder.
package csl_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        CSL_IDLE  = 2'b00,
        CSL_SEL   = 2'b01,
        CSL_LD    = 2'b10,
        CSL_LDSEL = 2'b11
    } csl_op_e;
endpackage

// File: rtl/csl_greater.sv
// Module: signed "strictly greater" comparator.
// Raises gt_o when in1 - in2 > 0, using a sign-extended difference one bit
// wider than the data so that overflow cannot corrupt the sign.
// Assumes two's-complement inputs.
module csl_greater #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] in1_i,
    input  logic [W-1:0] in2_i,
    output logic         gt_o
);
    localparam int unsigned XW = W + 1;

    logic [XW-1:0] diff;

    // Widened difference and the strictly-positive test on it.
    always_comb begin
        diff = {in1_i[W-1], in1_i} - {in2_i[W-1], in2_i};
        gt_o = ~diff[XW-1] & (|diff);
    end
endmodule

// File: rtl/csl_wordmem.sv
// Module: small word array standing in for data memory.
// One clocked preload write port and one combinational read port.
// A synchronous active-low reset clears every word. Reset wins over a write.
module csl_wordmem #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [IDXW-1:0] widx_i,
    input  logic [W-1:0]    wdata_i,
    input  logic [IDXW-1:0] ridx_i,
    output logic [W-1:0]    rdata_o
);
    logic [W-1:0] store_q [DEPTH];

    // One register per word: clear on reset, otherwise take a matching preload.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                store_q[g] <= '0;
            else if (we_i && (widx_i == IDXW'(g)))
                store_q[g] <= wdata_i;
        end
    end

    // Combinational read of the indexed word.
    assign rdata_o = store_q[ridx_i];

    // R9: a preload is visible in the next cycle at its index.
    a_r9_preload_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (store_q[$past(widx_i)] == $past(wdata_i)));
endmodule

// File: rtl/csl_exec_unit.sv
// Module: top of the compare-select execution unit.
// It chains select, array read and a second select in one cycle, with
// separate comparators for the two selects.
// Assumes op_i comes from an external decoder and results go straight to the
// register file write port.
module csl_exec_unit
    import csl_pkg::*;
#(
    parameter int unsigned W        = DATA_W,
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned ADDR_LSB = 2,
    localparam int unsigned IDXW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      op_i,
    input  logic [W-1:0]    src_a_i,
    input  logic [W-1:0]    src_b_i,
    input  logic            pre_we_i,
    input  logic [IDXW-1:0] pre_idx_i,
    input  logic [W-1:0]    pre_data_i,
    output logic            wb_en_o,
    output logic [W-1:0]    wb_data_o,
    output logic [W-1:0]    mem_addr_o
);
    csl_op_e      op;
    logic         a_gt_b;
    logic         a_gt_word;
    logic [W-1:0] max_ab;
    logic [W-1:0] word;
    logic [W-1:0] max_a_word;

    // Decode the raw code into the shared enum.
    assign op = csl_op_e'(op_i);

    // First compare: the larger source operand.
    csl_greater #(.W(W)) u_cmp_src (
        .in1_i (src_a_i),
        .in2_i (src_b_i),
        .gt_o  (a_gt_b)
    );

    // First select: an equal compare takes the second operand.
    assign max_ab = a_gt_b ? src_a_i : src_b_i;

    // Address presented to the array is the selected operand.
    assign mem_addr_o = max_ab;

    // Stand-in data memory, indexed by the word-select bits of the address.
    csl_wordmem #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (pre_we_i),
        .widx_i  (pre_idx_i),
        .wdata_i (pre_data_i),
        .ridx_i  (max_ab[ADDR_LSB +: IDXW]),
        .rdata_o (word)
    );

    // Second compare: first operand against the loaded word.
    csl_greater #(.W(W)) u_cmp_word (
        .in1_i (src_a_i),
        .in2_i (word),
        .gt_o  (a_gt_word)
    );

    // Second select: an equal compare takes the loaded word.
    assign max_a_word = a_gt_word ? src_a_i : word;

    // Write-back mux and enable for each operation.
    always_comb begin
        unique case (op)
            CSL_SEL:   begin wb_en_o = 1'b1; wb_data_o = max_ab;     end
            CSL_LD:    begin wb_en_o = 1'b1; wb_data_o = word;       end
            CSL_LDSEL: begin wb_en_o = 1'b1; wb_data_o = max_a_word; end
            default:   begin wb_en_o = 1'b0; wb_data_o = '0;         end
        endcase
    end

    // R1: idle produces no write and a zero value.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00) |-> (!wb_en_o && (wb_data_o == '0)));

    // R2: the select result is no smaller than either operand.
    a_r2_sel_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b01) |-> (($signed(wb_data_o) >= $signed(src_a_i)) &&
                             ($signed(wb_data_o) >= $signed(src_b_i))));

    // R6: the select-load-select result is no smaller than the first operand.
    a_r6_ldsel_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11) |-> ($signed(wb_data_o) >= $signed(src_a_i)));

    // R8: a load address is always one of the two operands.
    a_r8_addr_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[1]) |-> ((mem_addr_o == src_a_i) || (mem_addr_o == src_b_i)));

    // R7: any non-idle code raises the write enable.
    a_r7_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 2'b00) |-> wb_en_o);
endmodule

// File: tb/csl_exec_unit_tb_top.sv
// Directed bench: one task per scenario. Each task checks its own results.
module csl_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic        pre_we_i = 1'b0;
    logic [3:0]  pre_idx_i = '0;
    logic [31:0] pre_data_i = '0;
    logic        wb_en_o;
    logic [31:0] wb_data_o;
    logic [31:0] mem_addr_o;

    int total = 0;
    int bad = 0;
    logic [31:0] model [16];

    always #4 clk = ~clk;

    csl_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .pre_we_i(pre_we_i), .pre_idx_i(pre_idx_i),
        .pre_data_i(pre_data_i), .wb_en_o(wb_en_o), .wb_data_o(wb_data_o),
        .mem_addr_o(mem_addr_o)
    );

    function automatic logic [31:0] smax(input logic [31:0] x, input logic [31:0] y);
        return ($signed(x) > $signed(y)) ? x : y;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_i = op; src_a_i = a; src_b_i = b;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = '0;
    endtask

    task automatic preload(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        pre_we_i = 1'b1; pre_idx_i = idx; pre_data_i = val;
        @(negedge clk);
        pre_we_i = 1'b0;
        model[idx] = val;
    endtask

    task automatic t_idle();
        apply(2'b00, 32'h0000_0050, 32'h0000_0010);
        chk("R1 idle enable", {31'b0, wb_en_o}, 32'h0);
        chk("R1 idle data", wb_data_o, 32'h0);
    endtask

    task automatic t_select();
        logic [31:0] av [4] = '{32'h0000_0010, 32'hFFFF_FFFE, 32'h0000_0033, 32'hFFFF_FF00};
        logic [31:0] bv [4] = '{32'h0000_0020, 32'h0000_0001, 32'h0000_0033, 32'hFFFF_F000};
        for (int i = 0; i < 4; i++) begin
            apply(2'b01, av[i], bv[i]);
            chk("R2 select value", wb_data_o, smax(av[i], bv[i]));
            chk("R7 select enable", {31'b0, wb_en_o}, 32'h1);
        end
    endtask

    task automatic t_extremes();
        apply(2'b01, 32'h7FFF_FFFF, 32'h8000_0000);
        chk("R3 max positive vs min negative", wb_data_o, 32'h7FFF_FFFF);
        apply(2'b01, 32'h8000_0000, 32'h7FFF_FFFF);
        chk("R3 min negative vs max positive", wb_data_o, 32'h7FFF_FFFF);
        apply(2'b01, 32'h8000_0000, 32'h0000_0001);
        chk("R3 min negative vs one", wb_data_o, 32'h0000_0001);
    endtask

    task automatic t_load();
        apply(2'b10, 32'h0000_0008, 32'h0000_0004);
        chk("R4 load word 2", wb_data_o, model[2]);
        chk("R8 load address", mem_addr_o, 32'h0000_0008);
        chk("R7 load enable", {31'b0, wb_en_o}, 32'h1);
        apply(2'b10, 32'hFFFF_FFF0, 32'h0000_003C);
        chk("R4 load word 15", wb_data_o, model[15]);
    endtask

    task automatic t_addr_bits();
        apply(2'b10, 32'h0000_0047, 32'h0000_0000);
        chk("R5 low and high bits ignored", wb_data_o, model[1]);
        apply(2'b10, 32'h1234_5617, 32'h0000_0001);
        chk("R5 upper bits ignored", wb_data_o, model[5]);
    endtask

    task automatic t_ldsel();
        apply(2'b11, 32'h0000_0008, 32'h0000_0004);
        chk("R6 word below first operand", wb_data_o, smax(32'h0000_0008, model[2]));
        apply(2'b11, 32'h0000_0014, 32'hFFFF_FFFD);
        chk("R6 word above first operand", wb_data_o, smax(32'h0000_0014, model[5]));
        chk("R7 ldsel enable", {31'b0, wb_en_o}, 32'h1);
        apply(2'b11, 32'h0000_0000, 32'h0000_0024);
        chk("R6 second operand as address", wb_data_o, smax(32'h0000_0000, model[9]));
        chk("R8 ldsel address", mem_addr_o, 32'h0000_0024);
    endtask

    task automatic t_clear();
        do_reset();
        apply(2'b10, 32'h0000_0014, 32'h0000_0000);
        chk("R9 cleared after reset", wb_data_o, 32'h0);
        preload(4'd5, 32'hCAFE_0005);
        apply(2'b10, 32'h0000_0014, 32'h0000_0000);
        chk("R9 preload after reset", wb_data_o, 32'hCAFE_0005);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset();
        t_idle();
        for (int i = 0; i < 16; i++) preload(4'(i), 32'h1000_0000 + 32'(i) * 32'h111);
        preload(4'd2, 32'hFFFF_0000);
        preload(4'd5, 32'h7000_0000);
        preload(4'd9, 32'h8000_0001);
        t_select();
        t_extremes();
        t_load();
        t_addr_bits();
        t_ldsel();
        t_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule